// File: doc/BRIEF.md
# SDRAM Command Decoder with Mode Register

This block is a synchronous, device-side model of how an SDRAM interprets its control inputs. At each rising clock edge the chip-select and the three row, column and write strobes are sampled together and decoded as one command word. The top address bits pick one of four banks, and the low address bits carry the row, the column or the mode value, depending on the command. Each bank keeps its own open row. Writes store into that open row. Reads fetch from it and return the word after a programmable CAS latency.

The latency lives in a small mode register. A load-mode command writes it from the address lines. A controller can issue reads to several banks on back-to-back clocks and receive the words one per clock, in issue order. Reads and writes to a bank with no open row are refused and raise a sticky error flag.

Top module: `sdram_cmd_model`

## Requirements
- R1: When cs_n is high, or when {ras_n,cas_n,we_n} = 3'b111, the cycle is a no-operation. No bank opens or closes, nothing is written, no data is returned and the latency does not change. The encodings 3'b110 and 3'b001 are treated as no-operations as well.
- R2: Activate ({ras_n,cas_n,we_n} = 3'b011) opens row addr[2:0] in bank addr[7:6]. An activate to a bank that is already open replaces its open row.
- R3: Write (3'b100) to an open bank stores wdata at column addr[2:0] of that bank's open row.
- R4: Read (3'b101) to an open bank returns the word at column addr[2:0] of the open row. If the command is sampled at edge k, rdata holds the word and rvalid is high between edges k+CL-1 and k+CL. At all other times rvalid is low.
- R5: Load-mode (3'b000) sets the CAS latency CL to addr[6:4] when that value is 1, 2 or 3. Any other value is ignored and the previous CL is kept.
- R6: Precharge (3'b010) closes the open row of bank addr[7:6].
- R7: A read or write to a bank with no open row returns no data and changes no stored word. It sets err one edge later, and err then stays high until reset.
- R8: Reads to four different open banks on four consecutive clocks return their four words on four consecutive cycles, in issue order.
- R9: After reset, every bank is closed, rvalid and err are low, and CL is 3.
- R10: Banks are independent. Activating, writing or precharging one bank leaves the open row and the data of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every command is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low, part of the command word |
| cas_n | input | 1 | Column strobe, active low, part of the command word |
| we_n | input | 1 | Write strobe, active low, part of the command word |
| addr | input | 8 | Bits [7:6] select the bank; the low bits carry the row, the column or the mode value |
| wdata | input | 8 | Data stored by a write command |
| rdata | output | 8 | Read data |
| rvalid | output | 1 | High while rdata carries a read result |
| err | output | 1 | Sticky flag for an access to a closed bank |

## Verification
The assertion that ties rvalid to a recent read assumes the latency stays in its legal range. It also assumes no mode load happens while reads are still in flight. The bench keeps to both: it changes the latency only after the read pipeline has drained, and it issues at most one command per clock. The stimulus changes all inputs at the falling edge, so every sampled command word is stable. Accesses to closed banks are left until the end of the run, because the flag they raise stays set.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_LOAD = 3'd5
  } cmd_e;

  // Joint decode of the strobes sampled in one cycle.
  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) begin
      c = CMD_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b010:  c = CMD_PRE;
        3'b000:  c = CMD_LOAD;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

  // A latency is legal when it is between 1 and the pipeline depth.
  function automatic logic latency_ok(input int value, input int max_cl);
    return (value >= 1) && (value <= max_cl);
  endfunction

endpackage

// File: rtl/sdram_bank.sv
module sdram_bank #(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_i,
  input  logic              pre_i,
  input  logic              wr_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              open_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int WORDS = (1 << ROW_W) * (1 << COL_W);

  logic [DATA_W-1:0] cells [WORDS];
  logic [ROW_W-1:0]  row_q;
  logic              open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (act_i) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (pre_i) begin
      open_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_i && open_q) cells[{row_q, col_i}] <= wdata_i;
  end

  assign open_o  = open_q;
  assign rdata_o = cells[{row_q, col_i}];
endmodule

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_cmd_pkg::*;
#(
  parameter int CL_W     = 3,
  parameter int MAX_CL   = 3,
  parameter int RESET_CL = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [CL_W-1:0] value_i,
  output logic [CL_W-1:0] cl_o
);
  logic [CL_W-1:0] cl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cl_q <= CL_W'(RESET_CL);
    else if (load_i && latency_ok(int'(value_i), MAX_CL)) cl_q <= value_i;
  end

  assign cl_o = cl_q;
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3,
  parameter int CL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic [CL_W-1:0]   cl_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DEPTH-1:0]  vld_q;
  logic [DATA_W-1:0] dat_q  [DEPTH];
  logic [DEPTH-1:0]  vld_up;
  logic [DATA_W-1:0] dat_up [DEPTH];

  // Each stage takes the value of the stage above it; the top stage takes zero.
  for (genvar g = 0; g < DEPTH; g++) begin : g_up
    if (g == DEPTH - 1) begin : g_top
      assign vld_up[g] = 1'b0;
      assign dat_up[g] = '0;
    end else begin : g_mid
      assign vld_up[g] = vld_q[g+1];
      assign dat_up[g] = dat_q[g+1];
    end
  end

  // A new read enters at stage CL-1, so it reaches stage 0 after CL-1 shifts.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) dat_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (launch_i && (cl_i == CL_W'(i + 1))) begin
          vld_q[i] <= 1'b1;
          dat_q[i] <= data_i;
        end else begin
          vld_q[i] <= vld_up[i];
          dat_q[i] <= dat_up[i];
        end
      end
    end
  end

  assign valid_o = vld_q[0];
  assign data_o  = dat_q[0];
endmodule

// File: rtl/sdram_cmd_model.sv
module sdram_cmd_model
  import sdram_cmd_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 3,
  parameter int COL_W    = 3,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int CL_LSB   = 4,
  parameter int CL_W     = 3,
  parameter int MAX_CL   = 3,
  parameter int RESET_CL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              err
);
  localparam int NBANK = 1 << BANK_W;

  cmd_e cmd;
  assign cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);

  // Named command events, used by the datapath and by the checker.
  logic cmd_nop, cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_load;
  assign cmd_nop  = (cmd == CMD_NOP);
  assign cmd_act  = (cmd == CMD_ACT);
  assign cmd_rd   = (cmd == CMD_RD);
  assign cmd_wr   = (cmd == CMD_WR);
  assign cmd_pre  = (cmd == CMD_PRE);
  assign cmd_load = (cmd == CMD_LOAD);

  logic [BANK_W-1:0] bank_sel;
  logic [CL_W-1:0]   load_value;
  assign bank_sel   = addr[ADDR_W-1 -: BANK_W];
  assign load_value = addr[CL_LSB +: CL_W];

  logic [NBANK-1:0]  bank_open;
  logic [DATA_W-1:0] bank_rd [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = (bank_sel == BANK_W'(b));
    sdram_bank #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_i   (cmd_act && hit),
      .pre_i   (cmd_pre && hit),
      .wr_i    (cmd_wr && hit),
      .row_i   (addr[ROW_W-1:0]),
      .col_i   (addr[COL_W-1:0]),
      .wdata_i (wdata),
      .open_o  (bank_open[b]),
      .rdata_o (bank_rd[b])
    );
  end

  logic sel_open, access_fault, rd_launch;
  assign sel_open     = bank_open[bank_sel];
  assign access_fault = (cmd_rd || cmd_wr) && !sel_open;
  assign rd_launch    = cmd_rd && sel_open;

  logic err_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if (access_fault) err_q <= 1'b1;
  end
  assign err = err_q;

  logic [CL_W-1:0] cl;
  sdram_mode_reg #(.CL_W(CL_W), .MAX_CL(MAX_CL), .RESET_CL(RESET_CL)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (cmd_load),
    .value_i (load_value),
    .cl_o    (cl)
  );

  sdram_rd_pipe #(.DATA_W(DATA_W), .DEPTH(MAX_CL), .CL_W(CL_W)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (rd_launch),
    .cl_i     (cl),
    .data_i   (bank_rd[bank_sel]),
    .valid_o  (rvalid),
    .data_o   (rdata)
  );
endmodule

// File: rtl/sdram_cmd_model_chk.sv
module sdram_cmd_model_chk #(
  parameter int BANK_W = 2,
  parameter int CL_W   = 3,
  parameter int MAX_CL = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_nop,
  input logic                   cmd_act,
  input logic                   cmd_pre,
  input logic                   cmd_load,
  input logic [BANK_W-1:0]      bank_sel,
  input logic [(1<<BANK_W)-1:0] bank_open,
  input logic                   access_fault,
  input logic                   rd_launch,
  input logic [CL_W-1:0]        cl,
  input logic [CL_W-1:0]        load_value,
  input logic                   rvalid,
  input logic                   err
);
  assert_nop_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_nop |=> ($stable(bank_open) && $stable(cl)));

  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |=> bank_open[$past(bank_sel)]);

  assert_pre_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre |=> !bank_open[$past(bank_sel)]);

  assert_cl_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cl >= CL_W'(1)) && (cl <= CL_W'(MAX_CL)));

  assert_bad_load_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_load && !((load_value >= CL_W'(1)) && (load_value <= CL_W'(MAX_CL))))
      |=> $stable(cl));

  assert_fault_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    access_fault |=> err);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  if (MAX_CL == 3) begin : g_lat
    assert_rvalid_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |-> ($past(rd_launch, 1) || $past(rd_launch, 2) || $past(rd_launch, 3)));
  end
endmodule

bind sdram_cmd_model sdram_cmd_model_chk #(
  .BANK_W (BANK_W),
  .CL_W   (CL_W),
  .MAX_CL (MAX_CL)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_nop      (cmd_nop),
  .cmd_act      (cmd_act),
  .cmd_pre      (cmd_pre),
  .cmd_load     (cmd_load),
  .bank_sel     (bank_sel),
  .bank_open    (bank_open),
  .access_fault (access_fault),
  .rd_launch    (rd_launch),
  .cl           (cl),
  .load_value   (load_value),
  .rvalid       (rvalid),
  .err          (err)
);

// File: tb/sdram_cmd_model_bench.sv
`timescale 1ns/1ps
module sdram_cmd_model_bench;
  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                         C_PRE = 3'b010, C_LD = 3'b000, C_NOP = 3'b111;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic rvalid, err;

  sdram_cmd_model u_sdram_cmd_model (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .err(err)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic       lv [2048];
  logic [7:0] ld [2048];
  always @(negedge clk) if (cyc < 2048) begin lv[cyc] = rvalid; ld[cyc] = rdata; end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, hold across one rising edge, return at the next falling edge.
  task automatic issue(input logic csn, input logic [2:0] rcw, input logic [7:0] a,
                       input logic [7:0] d, output int e);
    cs_n = csn; {ras_n, cas_n, we_n} = rcw; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    e = cyc;
    cs_n = 1'b0; {ras_n, cas_n, we_n} = C_NOP; addr = '0; wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] bra(input int bank, input int low);
    return {bank[1:0], 3'b000, low[2:0]};
  endfunction

  // {cl[1:0], bank[1:0], row[2:0], col[2:0], data[7:0]}
  localparam logic [17:0] VEC [6] = '{
    {2'd1, 2'd0, 3'd2, 3'd5, 8'hA5},
    {2'd2, 2'd1, 3'd7, 3'd0, 8'h5A},
    {2'd3, 2'd2, 3'd0, 3'd7, 8'hC3},
    {2'd1, 2'd3, 3'd4, 3'd3, 8'h0F},
    {2'd2, 2'd3, 3'd5, 3'd3, 8'hF0},
    {2'd3, 2'd1, 3'd3, 3'd1, 8'h81}
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int e, e0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; cs_n = 1'b0;
    idle(1);

    // R9 reset state
    chk(rvalid == 1'b0, "R9 rvalid after reset", rvalid, 0);
    chk(err == 1'b0, "R9 err after reset", err, 0);

    // R9 default latency 3, with R2 activate and R3 write
    issue(0, C_ACT, bra(0, 1), 0, e);
    issue(0, C_WR, bra(0, 0), 8'h3C, e);
    issue(0, C_RD, bra(0, 0), 0, e);
    idle(4);
    chk(lv[e+1] == 1'b0, "R9 no data before CL3", lv[e+1], 0);
    chk(lv[e+2] && ld[e+2] == 8'h3C, "R9 R4 data at CL3", ld[e+2], 8'h3C);

    // Table walk: R2 R3 R4 R5 for each latency
    foreach (VEC[i]) begin
      int vcl, vb, vr, vc, vd;
      vcl = VEC[i][17:16]; vb = VEC[i][15:14]; vr = VEC[i][13:11];
      vc = VEC[i][10:8]; vd = VEC[i][7:0];
      issue(0, C_LD, {1'b0, vcl[2:0], 4'h0}, 0, e);
      issue(0, C_ACT, bra(vb, vr), 0, e);
      issue(0, C_WR, bra(vb, vc), vd[7:0], e);
      issue(0, C_RD, bra(vb, vc), 0, e);
      idle(4);
      chk(lv[e+vcl-1] && ld[e+vcl-1] == vd[7:0], "R4 table read", ld[e+vcl-1], vd);
      if (vcl > 1) chk(lv[e+vcl-2] == 1'b0, "R4 table early", lv[e+vcl-2], 0);
    end

    // R5 illegal loads ignored
    issue(0, C_ACT, bra(0, 6), 0, e);
    issue(0, C_WR, bra(0, 7), 8'h77, e);
    issue(0, C_LD, {1'b0, 3'd2, 4'h0}, 0, e);
    issue(0, C_LD, {1'b0, 3'd5, 4'h0}, 0, e);
    issue(0, C_LD, {1'b0, 3'd0, 4'h0}, 0, e);
    issue(0, C_RD, bra(0, 7), 0, e);
    idle(4);
    chk(lv[e] == 1'b0, "R5 latency not shortened", lv[e], 0);
    chk(lv[e+1] && ld[e+1] == 8'h77, "R5 latency kept at 2", ld[e+1], 8'h77);

    // R1 no-operations
    issue(1, C_WR, bra(0, 7), 8'h11, e);
    issue(0, C_NOP, bra(0, 7), 8'h22, e);
    issue(0, 3'b110, bra(0, 7), 8'h33, e);
    issue(1, C_RD, bra(0, 7), 0, e);
    idle(4);
    chk(!lv[e] && !lv[e+1] && !lv[e+2], "R1 deselected read gives no data", lv[e+1], 0);
    issue(0, C_RD, bra(0, 7), 0, e);
    idle(4);
    chk(lv[e+1] && ld[e+1] == 8'h77, "R1 word unchanged by no-ops", ld[e+1], 8'h77);

    // R8 R10 four banks, back-to-back reads
    for (int b = 0; b < 4; b++) issue(0, C_ACT, bra(b, 2), 0, e);
    for (int b = 0; b < 4; b++) issue(0, C_WR, bra(b, 3), 8'h10 + 8'(b * 17), e);
    issue(0, C_RD, bra(0, 3), 0, e0);
    for (int b = 1; b < 4; b++) issue(0, C_RD, bra(b, 3), 0, e);
    idle(5);
    for (int b = 0; b < 4; b++)
      chk(lv[e0+1+b] && ld[e0+1+b] == 8'h10 + 8'(b * 17), "R8 R10 ordered bank data",
          ld[e0+1+b], 8'h10 + b * 17);

    // R6 R7 precharge, closed-bank access, sticky error
    issue(0, C_PRE, bra(2, 0), 0, e);
    chk(err == 1'b0, "R6 precharge alone raises no error", err, 0);
    issue(0, C_RD, bra(2, 3), 0, e);
    chk(err == 1'b1, "R7 error after closed read", err, 1);
    issue(0, C_WR, bra(2, 3), 8'h99, e);
    idle(4);
    chk(!lv[e-1] && !lv[e] && !lv[e+1] && !lv[e+2], "R6 R7 no data from closed bank", 1, 0);
    chk(err == 1'b1, "R7 error sticky", err, 1);
    issue(0, C_RD, bra(1, 3), 0, e);
    idle(3);
    chk(lv[e+1] && ld[e+1] == 8'h21, "R10 other bank still open", ld[e+1], 8'h21);
    issue(0, C_ACT, bra(2, 2), 0, e);
    issue(0, C_RD, bra(2, 3), 0, e);
    idle(4);
    chk(lv[e+1] && ld[e+1] == 8'h32, "R7 closed write left word", ld[e+1], 8'h32);
    chk(err == 1'b1, "R7 error still set", err, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule